// File: doc/BRIEF.md
# Card Information Chain Walker

This engine walks the linked chains of card information tuples that a card keeps in two byte-addressed memories, attribute space and common space. On a start strobe it reads from address 0 of attribute space, one tuple at a time, through a synchronous read port. It follows long-link tuples and the implied hop from the first attribute chain to common space. It checks that every hop lands on a link-target tuple, and it passes each remaining tuple to a consumer as a code, a length and a start address on a valid/ready stream.

A tuple is a code byte, a length byte and then that many body bytes. The next tuple starts right after the body. In attribute space only even byte addresses hold data, so each tuple byte there sits two addresses after the previous one. Tuple bodies are not parsed into fields. The only body the walker reads is the 32-bit target of a long link.

Top module: `cw_walker`

## Requirements
- R1: After reset `done`, `err`, `t_valid` and `mem_req` are all 0.
- R2: A start strobe walks from attribute address 0. Each emitted tuple reports its code byte, its length byte and the address and space of its code byte. The next tuple begins 2 plus length bytes further on, with one byte step taking 2 addresses in attribute space (`mem_space`=0) and 1 address in common space (`mem_space`=1). A read returns `mem_rdata` on the cycle after `mem_req`.
- R3: Code 0x00 is a one-byte filler tuple. It has no length byte and is never emitted.
- R4: A chain ends at code 0xFF, or at a length byte of 0xFF (that tuple is not emitted). When the first attribute chain ends with no explicit link, the walk goes on at common address 0.
- R5: Code 0x14 (no-link) cancels the implied hop of its chain. With nothing pending, the end of the chain raises `done` with `err`=0.
- R6: Code 0x11 targets attribute space and code 0x12 targets common space. The body of either holds the target as 4 bytes, least significant first, of which only the low `ADDR_W` bits are kept. It replaces the implied hop, and the walk jumps to the target when its chain ends.
- R7: The first tuple at every hop destination must have code 0x13 (link target). Any other code stops the walk with `done`=1 and `err`=1.
- R8: A second long link in the same chain stops the walk with `done`=1 and `err`=1.
- R9: Codes 0x11, 0x12, 0x13 and 0x14 are emitted only if `ret_links` was 1 at the start strobe.
- R10: While `t_valid` is 1 and `t_ready` is 0, the stream fields hold their values.
- R11: `done` stays 1 until the next start strobe, and no reads are issued while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk (taken when idle or done) |
| ret_links | input | 1 | Also emit link-class tuples |
| mem_req | output | 1 | Read strobe |
| mem_space | output | 1 | 0 attribute, 1 common |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 8 | Read data, the cycle after the strobe |
| t_valid | output | 1 | Tuple available |
| t_ready | input | 1 | Consumer accepts the tuple |
| t_code | output | 8 | Tuple code |
| t_len | output | 8 | Body length |
| t_space | output | 1 | Space of the tuple |
| t_addr | output | ADDR_W | Address of the code byte |
| done | output | 1 | Walk finished |
| err | output | 1 | Walk stopped on a structural error |

## Verification
The bench builds the walker with `ADDR_W` = 12, so each 4 KB memory model covers a whole space. With that width, a long-link target whose upper body bytes are non-zero shows that bits above bit 11 are dropped. The directed layouts place a non-target byte at common address 0. A wrongly taken implied hop therefore shows up as an error instead of passing unseen. A periodic back-pressure pattern holds tuples on the stream across several cycles.

// File: rtl/cw_pkg.sv
// Shared codes, states and helpers for the chain walker.
// Assumes one byte per read and an 8-bit tuple code space.
package cw_pkg;
    localparam logic [7:0] CODE_NULL   = 8'h00;
    localparam logic [7:0] CODE_LL_ATT = 8'h11;
    localparam logic [7:0] CODE_LL_COM = 8'h12;
    localparam logic [7:0] CODE_TARGET = 8'h13;
    localparam logic [7:0] CODE_NOLINK = 8'h14;
    localparam logic [7:0] CODE_END    = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE, S_CODE_RQ, S_CODE_WT, S_LEN_RQ, S_LEN_WT,
        S_BODY_RQ, S_BODY_WT, S_LINK_SET, S_EMIT, S_ADV,
        S_CHAIN_END, S_DONE
    } walk_state_t;

    function automatic logic is_long(input logic [7:0] c);
        return (c == CODE_LL_ATT) || (c == CODE_LL_COM);
    endfunction

    function automatic logic is_link_class(input logic [7:0] c);
        return is_long(c) || (c == CODE_TARGET) || (c == CODE_NOLINK);
    endfunction
endpackage

// File: rtl/cw_addr_step.sv
// Adds a tuple byte offset to a base address in the selected space.
// Assumes attribute space (space=0) uses even addresses only, so the
// offset is doubled there; common space (space=1) is byte-packed.
module cw_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              space,
    input  logic [9:0]        off,
    output logic [ADDR_W-1:0] addr
);
    logic [10:0] scaled;

    // Scale the offset to the address stride of the space
    always_comb begin
        scaled = space ? {1'b0, off} : {off, 1'b0};
        addr   = base + ADDR_W'(scaled);
    end
endmodule

// File: rtl/cw_link_track.sv
// Holds the one pending long link of the current chain.
// arm loads the implied hop to common address 0; an explicit link
// replaces it; a no-link cancels only the implied one; take consumes it.
// dup reports a second explicit link in the same chain.
module cw_link_track #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cancel_dflt,
    input  logic              set_en,
    input  logic              set_space,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              take,
    output logic              pend_valid,
    output logic              pend_space,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              dup
);
    logic explicit_q;

    assign dup = set_en && explicit_q;

    // Track the pending hop for the chain being walked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            explicit_q <= 1'b0;
            pend_space <= 1'b0;
            pend_addr  <= '0;
        end else if (arm) begin
            pend_valid <= 1'b1;
            explicit_q <= 1'b0;
            pend_space <= 1'b1;
            pend_addr  <= '0;
        end else if (take) begin
            pend_valid <= 1'b0;
            explicit_q <= 1'b0;
        end else if (set_en && !explicit_q) begin
            pend_valid <= 1'b1;
            explicit_q <= 1'b1;
            pend_space <= set_space;
            pend_addr  <= set_addr;
        end else if (cancel_dflt && !explicit_q) begin
            pend_valid <= 1'b0;
        end
    end

    // R6
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !arm |=> !pend_valid);
    // R6
    link_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !dup && !arm && !take |=> pend_valid && pend_space == $past(set_space)
            && pend_addr == $past(set_addr));
endmodule

// File: rtl/cw_walker.sv
// Walks card information tuple chains across attribute and common space
// and streams the visible tuples. Assumes a read port whose data is valid
// the cycle after mem_req, and ADDR_W no wider than 32.
module cw_walker
    import cw_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ret_links,
    output logic              mem_req,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              t_valid,
    input  logic              t_ready,
    output logic [7:0]        t_code,
    output logic [7:0]        t_len,
    output logic              t_space,
    output logic [ADDR_W-1:0] t_addr,
    output logic              done,
    output logic              err
);
    walk_state_t       state;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_space;
    logic [7:0]        code_q;
    logic [7:0]        len_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [1:0]        bidx;
    logic              need_tgt;
    logic              ret_q;
    logic              err_q;

    logic [9:0]        fetch_off;
    logic [9:0]        next_off;
    logic [ADDR_W-1:0] fetch_addr;
    logic [ADDR_W-1:0] next_addr;

    logic              launch;
    logic              cancel_dflt;
    logic              set_en;
    logic              take;
    logic              pend_valid;
    logic              pend_space;
    logic [ADDR_W-1:0] pend_addr;
    logic              dup;

    // Offsets: byte to fetch now, and the size of the current tuple
    always_comb begin
        case (state)
            S_CODE_RQ: fetch_off = 10'd0;
            S_LEN_RQ:  fetch_off = 10'd1;
            default:   fetch_off = 10'd2 + {8'd0, bidx};
        endcase
        next_off = (code_q == CODE_NULL) ? 10'd1 : 10'd2 + {2'd0, len_q};
    end

    cw_addr_step #(.ADDR_W(ADDR_W)) u_fetch_step (
        .base(cur_addr), .space(cur_space), .off(fetch_off), .addr(fetch_addr)
    );

    cw_addr_step #(.ADDR_W(ADDR_W)) u_next_step (
        .base(cur_addr), .space(cur_space), .off(next_off), .addr(next_addr)
    );

    assign launch      = start && (state == S_IDLE || state == S_DONE);
    assign cancel_dflt = (state == S_LEN_WT) && (code_q == CODE_NOLINK) && (mem_rdata != CODE_END);
    assign set_en      = (state == S_LINK_SET);
    assign take        = (state == S_CHAIN_END) && pend_valid;

    cw_link_track #(.ADDR_W(ADDR_W)) u_links (
        .clk(clk), .rst_n(rst_n), .arm(launch), .cancel_dflt(cancel_dflt),
        .set_en(set_en), .set_space(code_q == CODE_LL_COM), .set_addr(tgt_q),
        .take(take), .pend_valid(pend_valid), .pend_space(pend_space),
        .pend_addr(pend_addr), .dup(dup)
    );

    // Read port and stream outputs follow the state
    always_comb begin
        mem_req   = (state == S_CODE_RQ) || (state == S_LEN_RQ) || (state == S_BODY_RQ);
        mem_space = cur_space;
        mem_addr  = fetch_addr;
        t_valid   = (state == S_EMIT);
        t_code    = code_q;
        t_len     = len_q;
        t_space   = cur_space;
        t_addr    = cur_addr;
        done      = (state == S_DONE);
        err       = err_q;
    end

    // Walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cur_addr  <= '0;
            cur_space <= 1'b0;
            code_q    <= '0;
            len_q     <= '0;
            bidx      <= '0;
            need_tgt  <= 1'b0;
            ret_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            case (state)
                S_IDLE, S_DONE: begin
                    if (launch) begin
                        cur_addr  <= '0;
                        cur_space <= 1'b0;
                        need_tgt  <= 1'b0;
                        ret_q     <= ret_links;
                        err_q     <= 1'b0;
                        state     <= S_CODE_RQ;
                    end
                end
                S_CODE_RQ: state <= S_CODE_WT;
                S_CODE_WT: begin
                    code_q <= mem_rdata;
                    if (need_tgt && mem_rdata != CODE_TARGET) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else if (mem_rdata == CODE_END) begin
                        state <= S_CHAIN_END;
                    end else if (mem_rdata == CODE_NULL) begin
                        state <= S_ADV;
                    end else begin
                        need_tgt <= 1'b0;
                        state    <= S_LEN_RQ;
                    end
                end
                S_LEN_RQ: state <= S_LEN_WT;
                S_LEN_WT: begin
                    len_q <= mem_rdata;
                    bidx  <= '0;
                    if (mem_rdata == CODE_END)
                        state <= S_CHAIN_END;
                    else if (is_long(code_q))
                        state <= S_BODY_RQ;
                    else if (!is_link_class(code_q) || ret_q)
                        state <= S_EMIT;
                    else
                        state <= S_ADV;
                end
                S_BODY_RQ: state <= S_BODY_WT;
                S_BODY_WT: begin
                    bidx  <= bidx + 2'd1;
                    state <= (bidx == 2'd3) ? S_LINK_SET : S_BODY_RQ;
                end
                S_LINK_SET: begin
                    if (dup) begin
                        err_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        state <= ret_q ? S_EMIT : S_ADV;
                    end
                end
                S_EMIT: if (t_ready) state <= S_ADV;
                S_ADV: begin
                    cur_addr <= next_addr;
                    state    <= S_CODE_RQ;
                end
                S_CHAIN_END: begin
                    if (pend_valid) begin
                        cur_addr  <= pend_addr;
                        cur_space <= pend_space;
                        need_tgt  <= 1'b1;
                        state     <= S_CODE_RQ;
                    end else begin
                        state <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Gather the long-link target, least significant byte first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else if (state == S_BODY_WT) begin
            for (int i = 0; i < ADDR_W; i++)
                if ((i / 8) == int'(bidx)) tgt_q[i] <= mem_rdata[i % 8];
        end
    end

    // R10
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_valid && !t_ready |=> t_valid && $stable(t_code) && $stable(t_len)
            && $stable(t_addr) && $stable(t_space));
    // R7
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |-> done);
    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req && !t_valid);
    // R9
    hide_links_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_valid && !ret_q |-> !is_link_class(t_code));
    // R2
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

// File: tb/cw_walker_tb.sv
module cw_walker_tb;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ret_links = 1'b0;
    logic          mem_req;
    logic          mem_space;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;
    logic          t_valid;
    logic          t_ready = 1'b1;
    logic [7:0]    t_code;
    logic [7:0]    t_len;
    logic          t_space;
    logic [AW-1:0] t_addr;
    logic          done;
    logic          err;

    logic [7:0] amem [4096];
    logic [7:0] cmem [4096];

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit stall_en = 1'b0;

    int got_n = 0;
    int got_code [16];
    int got_len  [16];
    int got_spc  [16];
    int got_addr [16];
    int exp_code [16];
    int exp_len  [16];
    int exp_spc  [16];
    int exp_addr [16];
    int exp_n = 0;

    bit   was_stalled = 1'b0;
    int   hold_code, hold_len, hold_spc, hold_addr;

    always #10 clk = ~clk;

    cw_walker #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ret_links(ret_links),
        .mem_req(mem_req), .mem_space(mem_space), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .t_valid(t_valid), .t_ready(t_ready),
        .t_code(t_code), .t_len(t_len), .t_space(t_space), .t_addr(t_addr),
        .done(done), .err(err)
    );

    // Synchronous memory model: data one cycle after the strobe
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) mem_rdata <= mem_space ? cmem[mem_addr] : amem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Consumer: choose ready, record transfers, watch held tuples (R10)
    always @(negedge clk) begin
        t_ready = !stall_en || (cyc % 3 != 0);
        if (was_stalled) begin
            check(t_valid == 1'b1, "R10", "valid held", int'(t_valid), 1);
            check(int'(t_code) == hold_code && int'(t_addr) == hold_addr &&
                  int'(t_len) == hold_len && int'(t_space) == hold_spc,
                  "R10", "fields held", int'(t_code), hold_code);
        end
        was_stalled = t_valid && !t_ready;
        hold_code = int'(t_code); hold_len = int'(t_len);
        hold_spc = int'(t_space); hold_addr = int'(t_addr);
        if (t_valid && t_ready && got_n < 16) begin
            got_code[got_n] = int'(t_code);
            got_len[got_n]  = int'(t_len);
            got_spc[got_n]  = int'(t_space);
            got_addr[got_n] = int'(t_addr);
            got_n++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic wipe();
        for (int i = 0; i < 4096; i++) begin
            amem[i] = 8'hFF;
            cmem[i] = 8'hFF;
        end
        cmem[0] = 8'h50;
        exp_n = 0;
    endtask

    task automatic pa(input int a, input int v); amem[a] = v[7:0]; endtask
    task automatic pc(input int a, input int v); cmem[a] = v[7:0]; endtask

    task automatic expect_t(input int c, input int l, input int s, input int a);
        exp_code[exp_n] = c; exp_len[exp_n] = l; exp_spc[exp_n] = s; exp_addr[exp_n] = a;
        exp_n++;
    endtask

    task automatic run_walk(input bit rl);
        @(negedge clk);
        got_n = 0;
        ret_links = rl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    endtask

    task automatic compare(input string req, input bit exp_err);
        check(done == 1'b1, req, "done", int'(done), 1);
        check(err == exp_err, req, "err", int'(err), int'(exp_err));
        check(got_n == exp_n, req, "tuple count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_code[i] == exp_code[i], req, "code", got_code[i], exp_code[i]);
            check(got_len[i] == exp_len[i], req, "len", got_len[i], exp_len[i]);
            check(got_spc[i] == exp_spc[i], req, "space", got_spc[i], exp_spc[i]);
            check(got_addr[i] == exp_addr[i], req, "addr", got_addr[i], exp_addr[i]);
        end
    endtask

    // Shared layout: attr chain with filler, implied hop into common
    task automatic layout_basic();
        wipe();
        pa(0, 8'h20); pa(2, 3); pa(4, 1); pa(6, 2); pa(8, 3);
        pa(10, 8'h00);
        pa(12, 8'h21); pa(14, 0);
        pa(16, 8'hFF);
        pc(0, 8'h13); pc(1, 3); pc(2, 8'h43); pc(3, 8'h49); pc(4, 8'h53);
        pc(5, 8'h22); pc(6, 1); pc(7, 8'h77);
        pc(8, 8'hFF);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1", "done", int'(done), 0);
        check(err == 1'b0, "R1", "err", int'(err), 0);
        check(t_valid == 1'b0, "R1", "t_valid", int'(t_valid), 0);
        check(mem_req == 1'b0, "R1", "mem_req", int'(mem_req), 0);
    endtask

    // R2 R3 R4: basic walk and the implied hop; R11 done held
    task automatic t_basic();
        layout_basic();
        expect_t(8'h20, 3, 0, 0);
        expect_t(8'h21, 0, 0, 12);
        expect_t(8'h22, 1, 1, 5);
        run_walk(1'b0);
        compare("R2/R3/R4", 1'b0);
        repeat (20) @(negedge clk);
        check(done == 1'b1, "R11", "done held", int'(done), 1);
        check(mem_req == 1'b0, "R11", "no reads", int'(mem_req), 0);
    endtask

    // R9: link-class tuples visible, with back-pressure for R10
    task automatic t_ret_links();
        layout_basic();
        stall_en = 1'b1;
        expect_t(8'h20, 3, 0, 0);
        expect_t(8'h21, 0, 0, 12);
        expect_t(8'h13, 3, 1, 0);
        expect_t(8'h22, 1, 1, 5);
        run_walk(1'b1);
        compare("R9", 1'b0);
        stall_en = 1'b0;
    endtask

    // R5: no-link cancels the hop; R4: length 0xFF ends the chain
    task automatic t_nolink();
        wipe();
        pa(0, 8'h14); pa(2, 0);
        pa(4, 8'h20); pa(6, 1); pa(8, 8'h99);
        pa(10, 8'h30); pa(12, 8'hFF);
        expect_t(8'h20, 1, 0, 4);
        run_walk(1'b0);
        compare("R5/R4", 1'b0);
    endtask

    // R6: explicit links in both directions, upper target bits dropped
    task automatic t_long_links();
        wipe();
        pa(0, 8'h12); pa(2, 4); pa(4, 8'h40); pa(6, 8'hF0); pa(8, 8'h00); pa(10, 8'h80);
        pa(12, 8'hFF);
        pc(8'h40, 8'h13); pc(8'h41, 3);
        pc(8'h45, 8'h23); pc(8'h46, 0);
        pc(8'h47, 8'h11); pc(8'h48, 4); pc(8'h49, 8'h20); pc(8'h4A, 0); pc(8'h4B, 0); pc(8'h4C, 0);
        pc(8'h4D, 8'hFF);
        pa(8'h20, 8'h13); pa(8'h22, 3);
        pa(8'h2A, 8'h24); pa(8'h2C, 2);
        pa(8'h32, 8'hFF);
        expect_t(8'h23, 0, 1, 8'h45);
        expect_t(8'h24, 2, 0, 8'h2A);
        run_walk(1'b0);
        compare("R6", 1'b0);
    endtask

    // R7: hop destination without a link target
    task automatic t_bad_target();
        wipe();
        pa(0, 8'h20); pa(2, 0); pa(4, 8'hFF);
        expect_t(8'h20, 0, 0, 0);
        run_walk(1'b0);
        compare("R7", 1'b1);
    endtask

    // R8: two explicit links in one chain
    task automatic t_dup_link();
        wipe();
        pa(0, 8'h11); pa(2, 4); pa(4, 8'h30); pa(6, 0); pa(8, 0); pa(10, 0);
        pa(12, 8'h12); pa(14, 4); pa(16, 0); pa(18, 0); pa(20, 0); pa(22, 0);
        pa(24, 8'hFF);
        run_walk(1'b0);
        compare("R8", 1'b1);
    endtask

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ret_links();
        t_nolink();
        t_long_links();
        t_bad_target();
        t_dup_link();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule